// File: doc/BRIEF.md
# Six-Phase Hard-Wired Instruction Sequencer

This block is the control unit of a small single-bus accumulator machine. A six-phase one-hot ring counter divides every instruction into six clock cycles. A decoder turns the 4-bit opcode from the instruction register into one line per opcode. A combinational control matrix then forms each datapath strobe as an OR of AND terms. Each term combines a timing phase, a decoded opcode line and, for the conditional jump only, the accumulator sign bit.

The first three phases always fetch the next instruction and need no opcode. The last three phases carry out the instruction now held in the instruction register. The registers, bus, ALU and memory sit outside the block. They obey the 16 strobes this block drives. A halt opcode stops the sequencer, and only reset starts it again.

Top module: `hwSequencer`

## Requirements
- R1: While `rstN` is low and just after it rises, the ring stands at T0, `halt` is 0, and the strobes show the T0 fetch pattern.
- R2: The ring moves forward exactly one phase on each rising clock edge, T0 through T5, and returns from T5 to T0. The bench counts phases from the release of reset.
- R3: The `strobes` bit map is: 0 pcInc, 1 pcOut, 2 pcLoad, 3 marLoad, 4 memRead, 5 memWrite, 6 mdrLoad, 7 mdrOut, 8 irLoad, 9 irOut, 10 accLoad, 11 accOut, 12 bLoad, 13 aluAdd, 14 aluSub, 15 aluOut. For every opcode, T0 drives pcOut and marLoad, T1 drives memRead, and T2 drives mdrOut, irLoad and pcInc.
- R4: Opcode 1 (load accumulator) drives irOut and marLoad in T3, memRead in T4, and mdrOut and accLoad in T5.
- R5: Opcode 2 (store accumulator) drives irOut and marLoad in T3, accOut and mdrLoad in T4, and memWrite in T5.
- R6: In T3, opcode 3 (add) drives aluAdd, aluOut and accLoad. Opcode 4 (subtract) drives aluSub, aluOut and accLoad. Opcode 5 (copy accumulator to B) drives accOut and bLoad.
- R7: Opcode 6 (jump) drives irOut and pcLoad in T3. Opcode 7 (jump if negative) does the same only when `negFlag` is 1.
- R8: Opcode 0 drives no strobe in T3 to T5. Any execute phase that an opcode does not use also drives no strobe.
- R9: Opcodes 8 to 15 raise `halt` in T3. `halt` then stays high until reset. The ring stays frozen and every strobe is 0, whatever `opcode` and `negFlag` do.
- R10: `negFlag` changes no strobe for any opcode other than 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode field of the instruction register |
| negFlag | input | 1 | Sign bit of the accumulator |
| strobes | output | 16 | Datapath control strobes, bit map in R3 |
| halt | output | 1 | Machine stopped |

## Verification
The hardest state to reach from the ports is the halted state. Once the sequencer enters it, the ring stops moving. Then the only thing that can be seen is that every strobe stays silent, even when a strobe-producing opcode and the sign bit are applied.

The bench therefore runs each halt opcode separately after a fresh reset and walks it up to T3. It then applies a load opcode with the sign bit set for several cycles and expects no strobe and a steady `halt`. A final reset shows that the block comes back at T0.

// File: rtl/hwSeqPkg.sv
package hwSeqPkg;

  localparam int OP_W   = 4;
  localparam int PHASES = 6;

  // Opcode values used by the control matrix
  localparam int OP_NOP  = 0;
  localparam int OP_LOAD = 1;
  localparam int OP_STOR = 2;
  localparam int OP_ADD  = 3;
  localparam int OP_SUB  = 4;
  localparam int OP_MOVB = 5;
  localparam int OP_JMP  = 6;
  localparam int OP_JNEG = 7;
  localparam int OP_HALT_FIRST = 8;

  // Packed so the first member is bit 15 and the last is bit 0
  typedef struct packed {
    logic aluOut;
    logic aluSub;
    logic aluAdd;
    logic bLoad;
    logic accOut;
    logic accLoad;
    logic irOut;
    logic irLoad;
    logic mdrOut;
    logic mdrLoad;
    logic memWrite;
    logic memRead;
    logic marLoad;
    logic pcLoad;
    logic pcOut;
    logic pcInc;
  } strobesT;

endpackage

// File: rtl/hwRing.sv
module hwRing #(
  parameter int PHASES = hwSeqPkg::PHASES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              haltReq,
  output logic [PHASES-1:0] phase,
  output logic              halted
);

  localparam logic [PHASES-1:0] START = {{(PHASES-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= START;
      halted <= 1'b0;
    end else if (!halted) begin
      if (haltReq) begin
        halted <= 1'b1;
      end else begin
        phase <= {phase[PHASES-2:0], phase[PHASES-1]};
      end
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones(phase) == 1);

  a_r2_rotate: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !haltReq) |=> (phase == {$past(phase[PHASES-2:0]), $past(phase[PHASES-1])}));

  a_r9_frozen: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(phase)));

endmodule

// File: rtl/hwDecode.sv
module hwDecode #(
  parameter int OP_W = hwSeqPkg::OP_W
) (
  input  logic [OP_W-1:0]       opcode,
  output logic [(1<<OP_W)-1:0]  lines
);

  localparam int LINES = 1 << OP_W;

  for (genvar i = 0; i < LINES; i++) begin : gLine
    assign lines[i] = (opcode == OP_W'(i));
  end

endmodule

// File: rtl/hwMatrix.sv
module hwMatrix #(
  parameter int OP_W   = hwSeqPkg::OP_W,
  parameter int PHASES = hwSeqPkg::PHASES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PHASES-1:0]     phase,
  input  logic [(1<<OP_W)-1:0]  lines,
  input  logic                  negFlag,
  input  logic                  halted,
  output hwSeqPkg::strobesT     ctl,
  output logic                  haltReq
);
  import hwSeqPkg::*;

  localparam int LINES = 1 << OP_W;

  logic t0, t1, t2, t3, t4, t5;
  logic isLoad, isStor, isAdd, isSub, isMovb, isJmp, isJneg, isHalt;
  strobesT raw;

  assign t0 = phase[0];
  assign t1 = phase[1];
  assign t2 = phase[2];
  assign t3 = phase[3];
  assign t4 = phase[4];
  assign t5 = phase[5];

  assign isLoad = lines[OP_LOAD];
  assign isStor = lines[OP_STOR];
  assign isAdd  = lines[OP_ADD];
  assign isSub  = lines[OP_SUB];
  assign isMovb = lines[OP_MOVB];
  assign isJmp  = lines[OP_JMP];
  assign isJneg = lines[OP_JNEG];
  assign isHalt = |lines[LINES-1:OP_HALT_FIRST];

  // Sum-of-products control matrix
  always_comb begin
    raw          = '0;
    raw.pcOut    = t0;
    raw.marLoad  = t0 | (t3 & isLoad) | (t3 & isStor);
    raw.memRead  = t1 | (t4 & isLoad);
    raw.mdrOut   = t2 | (t5 & isLoad);
    raw.irLoad   = t2;
    raw.pcInc    = t2;
    raw.irOut    = (t3 & isLoad) | (t3 & isStor) | (t3 & isJmp) | (t3 & isJneg & negFlag);
    raw.pcLoad   = (t3 & isJmp) | (t3 & isJneg & negFlag);
    raw.accOut   = (t4 & isStor) | (t3 & isMovb);
    raw.mdrLoad  = t4 & isStor;
    raw.memWrite = t5 & isStor;
    raw.accLoad  = (t5 & isLoad) | (t3 & isAdd) | (t3 & isSub);
    raw.aluAdd   = t3 & isAdd;
    raw.aluSub   = t3 & isSub;
    raw.aluOut   = (t3 & isAdd) | (t3 & isSub);
    raw.bLoad    = t3 & isMovb;
  end

  assign ctl     = halted ? '0 : raw;
  assign haltReq = t3 & isHalt & !halted;

  a_r3_fetch_read: assert property (@(posedge clk) disable iff (!rstN)
    (t1 && !halted) |-> (ctl.memRead && !ctl.memWrite && !ctl.marLoad));

  a_r7_jneg_gated: assert property (@(posedge clk) disable iff (!rstN)
    (t3 && lines[OP_JNEG] && !negFlag) |-> (!ctl.pcLoad && !ctl.irOut));

  a_r8_nop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((t3 || t4 || t5) && lines[OP_NOP]) |-> (ctl == '0));

endmodule

// File: rtl/hwSequencer.sv
module hwSequencer #(
  parameter int OP_W   = hwSeqPkg::OP_W,
  parameter int PHASES = hwSeqPkg::PHASES
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            negFlag,
  output logic [15:0]     strobes,
  output logic            halt
);

  localparam int LINES = 1 << OP_W;

  logic [PHASES-1:0] phase;
  logic [LINES-1:0]  lines;
  logic              halted;
  logic              haltReq;
  hwSeqPkg::strobesT ctl;

  hwRing #(.PHASES(PHASES)) uRing (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .phase(phase), .halted(halted)
  );

  hwDecode #(.OP_W(OP_W)) uDec (
    .opcode(opcode), .lines(lines)
  );

  hwMatrix #(.OP_W(OP_W), .PHASES(PHASES)) uMat (
    .clk(clk), .rstN(rstN), .phase(phase), .lines(lines), .negFlag(negFlag),
    .halted(halted), .ctl(ctl), .haltReq(haltReq)
  );

  assign strobes = ctl;
  assign halt    = halted | haltReq;

endmodule

// File: tb/sim_hwSequencer.sv
`timescale 1ns/1ps
module sim_hwSequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opcode = 4'd0;
  logic        negFlag = 1'b0;
  logic [15:0] strobes;
  logic        halt;

  int nChecks = 0;
  int nFails  = 0;
  int ph      = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  hwSequencer u0 (
    .clk(clk), .rstN(rstN), .opcode(opcode), .negFlag(negFlag),
    .strobes(strobes), .halt(halt)
  );

  localparam int B_PCINC = 0, B_PCOUT = 1, B_PCLD = 2, B_MARLD = 3, B_MRD = 4,
                 B_MWR = 5, B_MDRLD = 6, B_MDROUT = 7, B_IRLD = 8, B_IROUT = 9,
                 B_ACCLD = 10, B_ACCOUT = 11, B_BLD = 12, B_ADD = 13, B_SUB = 14,
                 B_ALUOUT = 15;

  function automatic logic [15:0] bitv(int b);
    return 16'(1) << b;
  endfunction

  function automatic logic [15:0] expStrobes(int op, bit nf, int p);
    logic [15:0] s = '0;
    case (p)
      0: s = bitv(B_PCOUT) | bitv(B_MARLD);
      1: s = bitv(B_MRD);
      2: s = bitv(B_MDROUT) | bitv(B_IRLD) | bitv(B_PCINC);
      3: case (op)
           1, 2: s = bitv(B_IROUT) | bitv(B_MARLD);
           3:    s = bitv(B_ADD) | bitv(B_ALUOUT) | bitv(B_ACCLD);
           4:    s = bitv(B_SUB) | bitv(B_ALUOUT) | bitv(B_ACCLD);
           5:    s = bitv(B_ACCOUT) | bitv(B_BLD);
           6:    s = bitv(B_IROUT) | bitv(B_PCLD);
           7:    s = nf ? (bitv(B_IROUT) | bitv(B_PCLD)) : '0;
           default: s = '0;
         endcase
      4: case (op)
           1: s = bitv(B_MRD);
           2: s = bitv(B_ACCOUT) | bitv(B_MDRLD);
           default: s = '0;
         endcase
      5: case (op)
           1: s = bitv(B_MDROUT) | bitv(B_ACCLD);
           2: s = bitv(B_MWR);
           default: s = '0;
         endcase
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic string reqOf(int op, int p);
    if (p < 3)            return "R3";
    if (op == 0)          return "R8";
    if (op == 1)          return "R4";
    if (op == 2)          return "R5";
    if (op >= 3 && op <= 5) return "R6";
    if (op == 6 || op == 7) return "R7";
    return "R9";
  endfunction

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h (op %0d nf %0b phase %0d)",
               req, what, act, exp, opcode, negFlag, ph);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state seen while reset is held
    #1 check("R1", "halt in reset", {15'd0, halt}, 16'd0);
    check("R1", "strobes in reset", strobes, expStrobes(0, 1'b0, 0));
    rstN = 1'b1;
    ph = 0;
  endtask

  initial begin
    rstN = 1'b0;
    opcode = 4'd0;
    negFlag = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    ph = 0;
    #1;
    // R1: first cycle after reset release is T0
    check("R1", "halt after reset", {15'd0, halt}, 16'd0);
    check("R1", "T0 after reset", strobes, expStrobes(0, 1'b0, 0));
    @(negedge clk);
    ph = 1;
    // walk to the next T0 (R2 ring count)
    while (ph != 0) begin
      #1 check("R2", "ring walk", strobes, expStrobes(0, 1'b0, ph));
      @(negedge clk);
      ph = (ph + 1) % 6;
    end

    // Sweep non-halting opcodes with both sign values (R3..R8, R10)
    for (int op = 0; op < 8; op++) begin
      for (int nf = 0; nf < 2; nf++) begin
        for (int p = 0; p < 6; p++) begin
          opcode  = 4'(op);
          negFlag = nf[0];
          #1;
          check(reqOf(op, ph), "strobes", strobes, expStrobes(op, nf[0], ph));
          if (op != 7) check("R10", "sign independence", strobes, expStrobes(op, 1'b0, ph));
          check("R2", "no halt", {15'd0, halt}, 16'd0);
          @(negedge clk);
          ph = (ph + 1) % 6;
        end
      end
    end

    // Halt opcodes, each from a fresh reset (R9)
    for (int op = 8; op < 16; op++) begin
      doReset();
      for (int p = 0; p < 4; p++) begin
        opcode  = 4'(op);
        negFlag = p[0];
        #1;
        check(p < 3 ? "R3" : "R9", "strobes before halt", strobes, expStrobes(op, p[0], ph));
        check("R9", "halt at phase", {15'd0, halt}, {15'd0, (p == 3)});
        @(negedge clk);
        if (p < 3) ph = ph + 1;
      end
      opcode  = 4'd1;
      negFlag = 1'b1;
      for (int k = 0; k < 8; k++) begin
        #1;
        check("R9", "halt held", {15'd0, halt}, 16'd1);
        check("R9", "strobes silent", strobes, 16'd0);
        @(negedge clk);
      end
    end

    // Recovery from halt by reset (R1)
    opcode  = 4'd2;
    negFlag = 1'b0;
    doReset();
    #1;
    check("R1", "halt cleared", {15'd0, halt}, 16'd0);
    check("R1", "T0 after recovery", strobes, expStrobes(2, 1'b0, 0));
    @(negedge clk);
    #1 check("R2", "T1 after recovery", strobes, expStrobes(2, 1'b0, 1));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule